// File: doc/BRIEF.md
# Multi-Mode Power-Down Controller

This block decides whether a processor core is executing, parked in a light idle, frozen in a deep idle, or parked in an externally requested standby. It has four named states: `ST_RUN`, `ST_LIGHT`, `ST_DEEP` and `ST_HOLD`. It turns that decision into three clock enables: one for the core, one for the on-chip peripherals, and one for the clock output pin. Registers keep their contents because only their clocks are gated and power is never removed. Execution therefore resumes unchanged on exit. The controller itself runs on an always-on clock, and all of its inputs are synchronous to that clock. One clock cycle is one machine cycle.

The state transitions are named as follows:
- `RUN->LIGHT` happens on the light-idle strobe. `LIGHT->RUN` happens on any pending interrupt, from any source.
- `RUN->DEEP` happens on the deep-idle strobe. `DEEP->RUN` happens only when one external wake pin has been held low for `WAKE_CYCLES` consecutive cycles. There is one qualifying counter per pin, and a pin's counter restarts whenever that pin goes high.
- `RUN->HOLD` happens when `hold_n` is low. `HOLD->RUN` happens when `hold_n` returns high.
- An asynchronous reset forces `ST_RUN` from any state.

Top module: `pwr_down_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the state is `ST_RUN` with `core_clk_en`, `periph_clk_en` and `clkout_en` all 1.
- R2: `idle_req` high in `ST_RUN` enters `ST_LIGHT` at the next edge: core enable 0, peripheral enable 1, clock-out enable 1. The block stays there while no interrupt is pending.
- R3: In `ST_LIGHT`, `irq_pending` high returns the block to `ST_RUN` (all enables 1) at the next edge.
- R4: `deep_req` high in `ST_RUN` enters `ST_DEEP` at the next edge, with all three enables 0.
- R5: In `ST_DEEP`, `irq_pending`, `hold_n` and the idle strobes have no effect, and all enables stay 0.
- R6: `ST_DEEP` is left for `ST_RUN` at the edge where one bit of `ext_pin_n` (bit 0 to 5, active low) is sampled low for the `WAKE_CYCLES`-th (default 5) consecutive time. Four consecutive low samples do not wake the block.
- R7: A wake pin that goes high before its count is complete restarts its count from zero. A later run must again reach the full `WAKE_CYCLES` samples.
- R8: `hold_n` low in `ST_RUN` enters `ST_HOLD` (core 0, peripheral 1, clock-out 1). `irq_pending` does not end it. `hold_n` high returns the block to `ST_RUN` at the next edge.
- R9: An idle strobe and a low `hold_n` in the same `ST_RUN` cycle enter the idle state. `hold_n` is ignored in `ST_LIGHT` and is evaluated again in the first `ST_RUN` cycle after wake-up.
- R10: `deep_req` and `idle_req` together in `ST_RUN` enter `ST_DEEP`.
- R11: Idle strobes received outside `ST_RUN` are ignored.
- R12: Asserting `rst_n` low from any state forces `ST_RUN` immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock, one cycle per machine cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Light-idle instruction strobe |
| deep_req | input | 1 | Deep-idle instruction strobe |
| hold_n | input | 1 | Active-low standby request |
| ext_pin_n | input | NUM_PINS | Active-low external wake pins (reset, NMI, four interrupts) |
| irq_pending | input | 1 | An interrupt from any source is pending |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| clkout_en | output | 1 | Clock output pin enable |

## Verification
The enables are decoded straight from the state register, so a wrong state shows at the ports in the same cycle it is entered. The exception is `ST_LIGHT` versus `ST_HOLD`: they drive identical enables and can only be told apart by which input releases them. A wrong wake count shows only at the edge where the pin completes, or fails to complete, its run of low samples. For that reason every deep-idle test holds a pin for one sample too few, and separately breaks a run partway through.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LIGHT = 2'd1,
        ST_DEEP  = 2'd2,
        ST_HOLD  = 2'd3
    } pd_state_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic clkout;
    } clk_en_t;
endpackage

// File: rtl/pdc_wake_qual.sv
module pdc_wake_qual #(
    parameter int WAKE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic pin_n,
    output logic wake
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    logic [CW-1:0] run_len;
    logic          pin_act;

    assign pin_act = !pin_n;
    assign wake    = armed && pin_act && (run_len == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= '0;
        else if (armed && pin_act && !wake)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    // R6: a wake is only ever preceded by an active pin sample
    p_wake_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(pin_act));
    // R7: once qualified, the count starts over
    p_wake_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (run_len == '0));
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
    import pdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_req,
    input  logic      deep_req,
    input  logic      hold_n,
    input  logic      irq_pending,
    input  logic      wake_any,
    output pd_state_e state
);
    pd_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (deep_req)      nxt = ST_DEEP;
                else if (idle_req) nxt = ST_LIGHT;
                else if (!hold_n)  nxt = ST_HOLD;
            end
            ST_LIGHT: if (irq_pending) nxt = ST_RUN;
            ST_DEEP:  if (wake_any)    nxt = ST_RUN;
            ST_HOLD:  if (hold_n)      nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    p_light_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LIGHT && irq_pending) |=> (state == ST_RUN));
    p_deep_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && !wake_any) |=> (state == ST_DEEP));
    p_hold_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_n) |=> (state == ST_RUN));
    p_strobe_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && idle_req && !deep_req && !hold_n) |=> (state == ST_LIGHT));
    p_deep_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && deep_req) |=> (state == ST_DEEP));
endmodule

// File: rtl/pdc_clk_decode.sv
module pdc_clk_decode
    import pdc_pkg::*;
(
    input  pd_state_e state,
    output clk_en_t   en
);
    always_comb begin
        en = '{core: 1'b1, periph: 1'b1, clkout: 1'b1};
        unique case (state)
            ST_RUN:   en = '{core: 1'b1, periph: 1'b1, clkout: 1'b1};
            ST_LIGHT: en = '{core: 1'b0, periph: 1'b1, clkout: 1'b1};
            ST_HOLD:  en = '{core: 1'b0, periph: 1'b1, clkout: 1'b1};
            ST_DEEP:  en = '{core: 1'b0, periph: 1'b0, clkout: 1'b0};
            default:  en = '{core: 1'b1, periph: 1'b1, clkout: 1'b1};
        endcase
    end
endmodule

// File: rtl/pwr_down_ctrl.sv
module pwr_down_ctrl
    import pdc_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int WAKE_CYCLES = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_req,
    input  logic                deep_req,
    input  logic                hold_n,
    input  logic [NUM_PINS-1:0] ext_pin_n,
    input  logic                irq_pending,
    output logic                core_clk_en,
    output logic                periph_clk_en,
    output logic                clkout_en
);
    pd_state_e           state;
    clk_en_t             en;
    logic [NUM_PINS-1:0] wake_vec;
    logic                armed;

    assign armed = (state == ST_DEEP);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pdc_wake_qual #(.WAKE_CYCLES(WAKE_CYCLES)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .armed (armed),
            .pin_n (ext_pin_n[p]),
            .wake  (wake_vec[p])
        );
    end

    pdc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_req    (idle_req),
        .deep_req    (deep_req),
        .hold_n      (hold_n),
        .irq_pending (irq_pending),
        .wake_any    (|wake_vec),
        .state       (state)
    );

    pdc_clk_decode u_dec (
        .state (state),
        .en    (en)
    );

    assign core_clk_en   = en.core;
    assign periph_clk_en = en.periph;
    assign clkout_en     = en.clkout;

    // R2: the core never runs while the peripherals are stopped
    p_core_needs_periph_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> periph_clk_en);
    // R4: leaving deep idle is only possible through a qualified pin
    p_deep_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_clk_en && !(|wake_vec)) |=> !periph_clk_en);
endmodule

// File: tb/pwr_down_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_down_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0, deep_req = 1'b0, hold_n = 1'b1, irq_pending = 1'b0;
    logic [5:0] ext_pin_n = 6'h3F;
    logic       core_clk_en, periph_clk_en, clkout_en;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    pwr_down_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .deep_req(deep_req),
        .hold_n(hold_n), .ext_pin_n(ext_pin_n), .irq_pending(irq_pending),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .clkout_en(clkout_en)
    );

    localparam logic [2:0] E_RUN  = 3'b111;
    localparam logic [2:0] E_PARK = 3'b011;
    localparam logic [2:0] E_OFF  = 3'b000;

    task automatic check(input logic [2:0] exp, input string tag);
        logic [2:0] act;
        act = {core_clk_en, periph_clk_en, clkout_en};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: enables actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // monitor: compare one cycle after each driven edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.exp, it.tag);
        end
    end

    task automatic step(input logic rv, input logic il, input logic dp, input logic hn,
                        input logic irq, input logic [5:0] pins,
                        input logic [2:0] exp, input string tag);
        @(negedge clk);
        rst_n = rv; idle_req = il; deep_req = dp; hold_n = hn;
        irq_pending = irq; ext_pin_n = pins;
        sb_q.push_back('{exp: exp, tag: tag});
    endtask

    function automatic logic [5:0] pin_low(input int k);
        return ~(6'b1 << k);
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(E_RUN, "R1 in reset");
        rst_n = 1'b1;
        step(1, 0, 0, 1, 0, 6'h3F, E_RUN, "R1 after release");

        // light idle
        step(1, 1, 0, 1, 0, 6'h3F, E_PARK, "R2 enter light");
        step(1, 0, 0, 1, 0, 6'h3F, E_PARK, "R2 stay light");
        step(1, 0, 1, 1, 0, 6'h3F, E_PARK, "R11 deep strobe ignored in light");
        step(1, 0, 0, 1, 1, 6'h3F, E_RUN,  "R3 irq ends light");

        // deep idle, insufficient and broken runs
        step(1, 0, 1, 1, 0, 6'h3F, E_OFF, "R4 enter deep");
        step(1, 0, 0, 0, 1, 6'h3F, E_OFF, "R5 irq and hold ignored");
        step(1, 1, 0, 1, 0, 6'h3F, E_OFF, "R11 idle strobe ignored in deep");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, pin_low(0), E_OFF, "R6 short run");
        step(1, 0, 0, 1, 0, 6'h3F, E_OFF, "R7 pin released");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, pin_low(3), E_OFF, "R7 run part");
        step(1, 0, 0, 1, 0, 6'h3F, E_OFF, "R7 run broken");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, pin_low(3), E_OFF, "R7 restarted run");
        step(1, 0, 0, 1, 0, pin_low(3), E_RUN, "R6 fifth sample wakes");

        // both strobes
        step(1, 1, 1, 1, 0, 6'h3F, E_OFF, "R10 deep wins");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, pin_low(5), E_OFF, "R6 pin5 counting");
        step(1, 0, 0, 1, 0, pin_low(5), E_RUN, "R6 pin5 wakes");

        // hold
        step(1, 0, 0, 0, 0, 6'h3F, E_PARK, "R8 enter hold");
        step(1, 0, 0, 0, 1, 6'h3F, E_PARK, "R8 irq does not end hold");
        step(1, 0, 0, 1, 0, 6'h3F, E_RUN,  "R8 hold released");

        // strobe versus hold
        step(1, 1, 0, 0, 0, 6'h3F, E_PARK, "R9 strobe wins over hold");
        step(1, 0, 0, 1, 0, 6'h3F, E_PARK, "R9 light not released by hold_n");
        step(1, 0, 0, 0, 1, 6'h3F, E_RUN,  "R9 wake from light");
        step(1, 0, 0, 0, 0, 6'h3F, E_PARK, "R9 hold re-evaluated");
        step(1, 0, 0, 0, 1, 6'h3F, E_PARK, "R9 in hold, irq ignored");
        step(1, 0, 0, 1, 0, 6'h3F, E_RUN,  "R9 hold exit");

        // reset from other states
        step(1, 0, 1, 1, 0, 6'h3F, E_OFF, "R4 deep again");
        step(0, 0, 0, 1, 0, 6'h3F, E_RUN, "R12 reset from deep");
        step(1, 0, 0, 1, 0, 6'h3F, E_RUN, "R12 run after reset");
        step(1, 0, 0, 0, 0, 6'h3F, E_PARK, "R8 hold again");
        step(0, 0, 0, 0, 0, 6'h3F, E_RUN, "R12 reset from hold");
        step(1, 0, 0, 1, 0, 6'h3F, E_RUN, "R12 run after release");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule